// File: doc/BRIEF.md
# Serial DAC Word Writer

This block sits on the host side of a three-wire serial digital-to-analog converter link. It takes one 12-bit straight-binary code at a time through a valid/ready handshake. It produces the serial clock, the data line, an active-low select and an active-low load strobe that the converter needs to receive the code. For each accepted word it asserts select and waits a short setup time. It then clocks the bits out starting with the most significant one and releases select. Only after that does it drop the load strobe, so the converter's transparent output register takes the whole word at once.

The serial clock is derived from the system clock by a divider parameter. A divider of `CLK_DIV` gives a serial period of `2*CLK_DIV` system clocks. The serial clock rests low, and each bit period spends its first half low and its second half high. Data changes together with the falling edge, so it is steady when the converter samples on the rising edge. The load pulse width is a separate parameter, `LOAD_CYC`, which the integrator sets to at least one serial period (`2*CLK_DIV`). The block refuses new words from the cycle after acceptance until the load strobe is high again and a short recovery gap has passed.

Top module: `sdac_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `dac_cs_n`=1, `dac_ld_n`=1, `dac_sclk`=0, `dac_sdo`=0 and `in_ready`=1.
- R2: `in_ready` is 1 only when the block is idle. A word is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 from the next cycle for exactly `(2*12+3)*CLK_DIV + LOAD_CYC` cycles.
- R3: `dac_cs_n` goes low in the first cycle after acceptance and stays low for `CLK_DIV` cycles before the first rising edge of `dac_sclk`.
- R4: `dac_sclk` is low whenever `dac_cs_n` is high. Each bit takes `CLK_DIV` cycles low followed by `CLK_DIV` cycles high, and exactly 12 rising edges occur per select window.
- R5: Bits leave most significant first: at the k-th rising edge (k=0..11) `dac_sdo` equals code bit 11-k. While select is active, `dac_sdo` changes only in the cycle where `dac_sclk` falls.
- R6: `dac_cs_n` returns high in the same cycle that the 12th high half ends, and it stays high for `CLK_DIV` cycles before `dac_ld_n` falls.
- R7: `dac_ld_n` goes low only after select has been released, and it stays low for exactly `LOAD_CYC` cycles once per word.
- R8: `dac_ld_n` is high in every cycle in which `dac_cs_n` is low.
- R9: `in_valid` and `in_code` have no effect while `in_ready` is 0. The word being shifted is the one captured at acceptance.
- R10: After the load pulse ends, `in_ready` returns to 1 after `CLK_DIV` more cycles. A word presented then is accepted at once, and its transfer follows the same timing with no merging of words.
- R11: `dac_sdo` is 0 in every cycle in which `dac_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host offers a code |
| in_code | input | 12 | Straight-binary code to send |
| in_ready | output | 1 | Block is idle and will take a code |
| dac_sclk | output | 1 | Serial clock to the converter, rests low |
| dac_sdo | output | 1 | Serial data, MSB first |
| dac_cs_n | output | 1 | Active-low select framing the shift |
| dac_ld_n | output | 1 | Active-low load strobe into the output register |

## Verification
The codes used are all-ones, all-zeros, the midscale pair 0x800/0x7FF, midscale plus one and an alternating 0xA5A. Between them they show a stuck or inverted data line, a reversed bit order and a shift by one position. Isolated words with idle gaps check the select setup and release timing. A word followed at once by further words with `in_valid` held high checks the recovery gap and the restart out of idle. A second code driven with `in_valid` high during a transfer must leave the shifted bits and every pin timing unchanged. A behavioural cycle counter in the bench predicts every pin in every cycle and finds off-by-one phase lengths.

// File: rtl/sdac_pkg.sv
// Package: shared types for the serial DAC word writer.
// Assumes: nothing beyond IEEE 1800-2017.
package sdac_pkg;

    // Transfer phases, in the order one word passes through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SHIFT,
        ST_DESEL,
        ST_LOAD,
        ST_RECOV
    } sdac_state_t;

endpackage

// File: rtl/sdac_phase_timer.sv
// Module: phase timer. Counts system clocks inside the current phase and
// flags the last cycle of it, then wraps to zero by itself.
// Assumes: len >= 1 and len does not change except on a wrap or a clear.
module sdac_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] len,
    output logic          last
);

    logic [CW-1:0] cnt;

    // Flag the final cycle of the phase.
    assign last = (cnt == len - CW'(1));

    // Advance the count, restarting on clear or at the end of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt < len)); // R4

endmodule

// File: rtl/sdac_shreg.sv
// Module: output shift register. Captures a word on load and moves it one
// place toward the MSB end on shift; the MSB is the bit on the wire.
// Assumes: load and shift are never requested in the same cycle.
module sdac_shreg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);

    logic [W-1:0] sreg;

    assign msb = sreg[W-1];

    // Hold the word being sent, shifting left at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift)); // R9

endmodule

// File: rtl/sdac_seq.sv
// Module: transfer sequencer. Walks each word through select setup, the
// bit-by-bit shift, select release, the load pulse and a recovery gap, and
// decodes the pin levels and shift-register controls from its state.
// Assumes: the phase timer's last flag refers to the len this module drives.
module sdac_seq
    import sdac_pkg::*;
#(
    parameter int W        = 12,
    parameter int CW       = 4,
    parameter int CLK_DIV  = 4,
    parameter int LOAD_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          last,
    output logic          timer_clr,
    output logic [CW-1:0] len,
    output logic          sh_load,
    output logic          sh_shift,
    output logic          sdo_en,
    output logic          cs_n,
    output logic          sclk,
    output logic          ld_n,
    output logic          ready
);

    localparam int BW = (W > 1) ? $clog2(W) : 1;

    sdac_state_t   state;
    logic          half;
    logic [BW-1:0] bitcnt;
    logic          last_bit;

    assign last_bit = (bitcnt == BW'(W - 1));

    // Phase length: the load pulse has its own width, all others a half period.
    assign len       = (state == ST_LOAD) ? CW'(LOAD_CYC) : CW'(CLK_DIV);
    assign timer_clr = (state == ST_IDLE);

    // Pin and control decode.
    assign ready    = (state == ST_IDLE);
    assign sh_load  = (state == ST_IDLE) && in_valid;
    assign sh_shift = (state == ST_SHIFT) && half && last && !last_bit;
    assign sdo_en   = (state == ST_SEL) || (state == ST_SHIFT);
    assign cs_n     = !sdo_en;
    assign sclk     = (state == ST_SHIFT) && half;
    assign ld_n     = (state != ST_LOAD);

    // Step through the phases of one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            half   <= 1'b0;
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (last) begin
                        state  <= ST_SHIFT;
                        half   <= 1'b0;
                        bitcnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (last) begin
                        if (!half) begin
                            half <= 1'b1;
                        end else begin
                            half <= 1'b0;
                            if (last_bit) begin
                                state <= ST_DESEL;
                            end else begin
                                bitcnt <= bitcnt + BW'(1);
                            end
                        end
                    end
                end
                ST_DESEL: begin
                    if (last) begin
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (last) begin
                        state <= ST_RECOV;
                    end
                end
                ST_RECOV: begin
                    if (last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt < BW'(W)); // R4
    AST_SHIFT_ONLY_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sh_shift |-> sclk); // R5

endmodule

// File: rtl/sdac_writer.sv
// Module: serial DAC word writer (top). Accepts a 12-bit code on a
// valid/ready handshake and sends it to a serial DAC: select, MSB-first
// shift on a divided clock, release, then a load pulse.
// Assumes: LOAD_CYC >= 2*CLK_DIV and CLK_DIV >= 1, set by the integrator.
module sdac_writer #(
    parameter int W        = 12,
    parameter int CLK_DIV  = 4,
    parameter int LOAD_CYC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_code,
    output logic         in_ready,
    output logic         dac_sclk,
    output logic         dac_sdo,
    output logic         dac_cs_n,
    output logic         dac_ld_n
);

    localparam int MAXLEN = (LOAD_CYC > CLK_DIV) ? LOAD_CYC : CLK_DIV;
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam int EW     = $clog2(W + 1) + 1;

    logic          timer_clr;
    logic [CW-1:0] len;
    logic          last;
    logic          sh_load;
    logic          sh_shift;
    logic          sdo_en;
    logic          msb;

    sdac_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .len   (len),
        .last  (last)
    );

    sdac_seq #(
        .W        (W),
        .CW       (CW),
        .CLK_DIV  (CLK_DIV),
        .LOAD_CYC (LOAD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .last      (last),
        .timer_clr (timer_clr),
        .len       (len),
        .sh_load   (sh_load),
        .sh_shift  (sh_shift),
        .sdo_en    (sdo_en),
        .cs_n      (dac_cs_n),
        .sclk      (dac_sclk),
        .ld_n      (dac_ld_n),
        .ready     (in_ready)
    );

    sdac_shreg #(.W(W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (in_code),
        .msb   (msb)
    );

    // Data line is quiet outside the select window.
    assign dac_sdo = sdo_en && msb;

    // Rising-edge tally per select window, used by the edge-count check.
    logic          sclk_q;
    logic [EW-1:0] edge_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            edge_cnt <= '0;
        end else begin
            sclk_q <= dac_sclk;
            if (dac_cs_n) begin
                edge_cnt <= '0;
            end else if (dac_sclk && !sclk_q) begin
                edge_cnt <= edge_cnt + EW'(1);
            end
        end
    end

    AST_LD_HIGH_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> dac_ld_n); // R8
    AST_SCLK_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk); // R4
    AST_TWELVE_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (edge_cnt == EW'(W))); // R4
    AST_SDO_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> $stable(dac_sdo)); // R5
    AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && !$past(dac_cs_n) && (dac_sdo != $past(dac_sdo))) |-> $fell(dac_sclk)); // R5
    AST_SDO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sdo); // R11
    AST_LOAD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ld_n) |-> $past(dac_cs_n)); // R7
    AST_BUSY_DURING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> !in_ready); // R2

endmodule

// File: tb/sdac_writer_bench.sv
`timescale 1ns/1ps
module sdac_writer_bench;

    localparam int W     = 12;
    localparam int D     = 3;
    localparam int L     = 7;
    localparam int TOTAL = (2 * W + 3) * D + L;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_code = '0;
    logic         in_ready, dac_sclk, dac_sdo, dac_cs_n, dac_ld_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sdac_writer #(.W(W), .CLK_DIV(D), .LOAD_CYC(L)) u_sdac_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_code  (in_code),
        .in_ready (in_ready),
        .dac_sclk (dac_sclk),
        .dac_sdo  (dac_sdo),
        .dac_cs_n (dac_cs_n),
        .dac_ld_n (dac_ld_n)
    );

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: cycles since acceptance.
    bit           m_busy = 1'b0;
    bit           m_live = 1'b0;
    int           m_t = 0;
    logic [W-1:0] m_code = '0;

    always @(posedge clk) begin
        m_live <= rst_n;
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_t    <= 0;
        end else if (!m_busy) begin
            if (in_valid) begin
                m_busy <= 1'b1;
                m_t    <= 0;
                m_code <= in_code;
            end
        end else if (m_t == TOTAL - 1) begin
            m_busy <= 1'b0;
        end else begin
            m_t <= m_t + 1;
        end
    end

    // Per-cycle comparison of all pins with the model.
    always @(negedge clk) begin
        if (m_live) begin
            automatic logic e_cs = 1'b1, e_sclk = 1'b0, e_sdo = 1'b0, e_ld = 1'b1, e_rdy = 1'b1;
            if (m_busy) begin
                e_rdy = 1'b0;
                if (m_t < D) begin
                    e_cs = 1'b0; e_sdo = m_code[W-1];
                end else if (m_t < D + 2 * W * D) begin
                    automatic int u = m_t - D;
                    e_cs   = 1'b0;
                    e_sclk = ((u % (2 * D)) >= D);
                    e_sdo  = m_code[W - 1 - u / (2 * D)];
                end else if (m_t >= 2 * W * D + 2 * D && m_t < 2 * W * D + 2 * D + L) begin
                    e_ld = 1'b0;
                end
            end
            check("R2", "in_ready", in_ready, e_rdy);
            check((m_busy && m_t >= D) ? "R6" : "R3", "dac_cs_n", dac_cs_n, e_cs);
            check("R4", "dac_sclk", dac_sclk, e_sclk);
            check(e_cs ? "R11" : "R5", "dac_sdo", dac_sdo, e_sdo);
            check("R7", "dac_ld_n", dac_ld_n, e_ld);
            if (!dac_cs_n) check("R8", "dac_ld_n while selected", dac_ld_n, 1);
        end
    end

    // Word capture from the wire, plus release-to-load gap.
    logic [W-1:0] sent_q[$];
    string        cur_tag = "R5";
    logic [W-1:0] cap = '0;
    int           nrise = 0;
    int           gap = 0;
    logic         p_sclk = 1'b0, p_cs = 1'b1, p_ld = 1'b1;

    always @(negedge clk) begin
        if (m_live) begin
            if (!dac_cs_n && p_cs) begin
                cap = '0; nrise = 0;
            end
            if (!dac_cs_n && dac_sclk && !p_sclk) begin
                cap = {cap[W-2:0], dac_sdo}; nrise++;
            end
            if (dac_cs_n && !p_cs) begin
                automatic logic [W-1:0] exp_w = (sent_q.size() > 0) ? sent_q.pop_front() : '0;
                check("R4", "rising edges per word", nrise, W);
                check(cur_tag, "word seen on wire", cap, exp_w);
                gap = 0;
            end
            if (dac_cs_n && dac_ld_n) gap++;
            if (!dac_ld_n && p_ld) check("R6", "release-to-load cycles", gap, D);
            p_sclk = dac_sclk; p_cs = dac_cs_n; p_ld = dac_ld_n;
        end
    end

    task automatic send(logic [W-1:0] c);
        sent_q.push_back(c);
        in_valid = 1'b1;
        in_code  = c;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "cs_n in reset", dac_cs_n, 1);
        check("R1", "ld_n in reset", dac_ld_n, 1);
        check("R1", "sclk in reset", dac_sclk, 0);
        check("R1", "sdo in reset", dac_sdo, 0);
        check("R1", "ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", in_ready, 1);
        check("R1", "cs_n after reset", dac_cs_n, 1);

        // Isolated words with distinct bit patterns.
        send(12'hFFF); wait_idle();
        send(12'h000); wait_idle();
        send(12'h800); wait_idle();
        send(12'h7FF); wait_idle();
        send(12'h801); wait_idle();

        // R9: other codes offered while busy must be ignored.
        cur_tag = "R9";
        send(12'hA5A);
        in_valid = 1'b1;
        for (int i = 0; i < 20; i++) begin
            in_code = 12'h5A5 ^ W'(i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        wait_idle();

        // R10: back-to-back words, valid held until each is taken.
        cur_tag = "R10";
        send(12'h123);
        send(12'hFED);
        send(12'h001);
        wait_idle();
        check("R10", "all words delivered", sent_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule